// File: doc/BRIEF.md
# CAN Controller Operating-Mode Sequencer

This block sits beside a CAN protocol engine and owns the engine's low-power and configuration modes. Software writes two request bits, one for sleep and one for configuration (initialization). The block answers each with an acknowledge bit. A sleep request is granted only once the bus is quiet. A configuration request is granted at once: it cuts off traffic, forces the transmit output recessive and opens the configuration registers for writing.

When configuration mode is released, the block runs bus integration. It counts recessive bit times on the sampled receive line until the controller may rejoin the bus, and only then does it raise the synchronized indication. A controller that is bus-off waits for a much longer run of idle bus time before it rejoins.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset, init_req, init_ack and tx_force_rec are 1, and sleep_req, sleep_ack, bus_synced and eng_abort are 0.
- R2: sleep_ack rises one clock after a clock edge at which sleep_req is 1 and the bus is idle, meaning rx_busy=0 and tx_pending=0. It never rises while the bus is busy.
- R3: A CPU write of sleep=1 is ignored (sleep_req stays 0) while wake_pend is 1.
- R4: While sleep_ack=1, wake_en=1 and rx_line=0 (dominant), sleep_req clears at the next edge. With wake_en=0, bus activity has no effect on sleep_req.
- R5: A CPU write of init=1 sets init_req at the next edge. For that first cycle only, eng_abort is 1 and init_ack is 0. init_ack follows one clock later, and bus_synced is 0 throughout configuration mode.
- R6: A CPU write that clears a request bit is ignored while that bit's acknowledge is 0.
- R7: Each acknowledge falls one clock after its request bit is cleared.
- R8: cfg_wr_en is 1 exactly when init_req=1 and init_ack=1.
- R9: After init_req and init_ack are both 0, and bus_off=0, bus_synced rises at the 11th consecutive bit_strobe that samples rx_line=1. A strobe that samples rx_line=0 restarts the count.
- R10: With bus_off=1, bus_synced rises only after 128 completed runs of 11 recessive strobes.
- R11: tx_force_rec is 1 whenever init_req=1 or bus_synced=0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | CPU write strobe for the request bits |
| cpu_sleep | input | 1 | Sleep request value written |
| cpu_init | input | 1 | Configuration request value written |
| wake_pend | input | 1 | Wake-up interrupt flag pending |
| wake_en | input | 1 | Wake-up on bus activity enabled |
| rx_busy | input | 1 | Reception in progress |
| tx_pending | input | 1 | At least one transmit buffer full |
| rx_line | input | 1 | Sampled receive line, 1 = recessive |
| bit_strobe | input | 1 | One pulse per bit time |
| bus_off | input | 1 | Controller is in bus-off state |
| sleep_req | output | 1 | Sleep request bit |
| sleep_ack | output | 1 | Sleep acknowledge |
| init_req | output | 1 | Configuration request bit |
| init_ack | output | 1 | Configuration acknowledge |
| tx_force_rec | output | 1 | Force transmit output recessive |
| eng_abort | output | 1 | One-cycle abort pulse to the protocol engine |
| cfg_wr_en | output | 1 | Configuration registers writable |
| bus_synced | output | 1 | Bus integration complete |

## Verification
The bench tries to clear each request bit in the cycle before its acknowledge arrives. A design without the lock would drop the request and leave a stale or missing acknowledge. A dominant sample is placed in the middle of an integration run. A counter that fails to restart would report synchronization several bit times early. The bus-off path is run through all 128 runs, and the bench checks one strobe before the last. An off-by-one in the occurrence count shows as an early or late rise of bus_synced. The bench also sends a sleep request while the bus is busy, while a wake-up is pending, and with bus activity present both with and without wake-up enabled.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
   localparam int unsigned CMC_RUN_LEN = 11;
   localparam int unsigned CMC_OCC_LEN = 128;

   typedef struct packed {
      logic req;
      logic ack;
   } cmc_hs_t;
endpackage

// File: rtl/can_mode_hs.sv
module can_mode_hs #(
   parameter bit RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_val,
   input  logic set_block,
   input  logic enter_ok,
   input  logic auto_clr,
   output can_mode_pkg::cmc_hs_t hs
);
   can_mode_pkg::cmc_hs_t hs_q;
   logic req_nxt;

   always_comb begin
      req_nxt = hs_q.req;
      if (wr_en) begin
         if (wr_val && !set_block)
            req_nxt = 1'b1;
         else if (!wr_val && hs_q.ack)
            req_nxt = 1'b0;
      end
      if (auto_clr && hs_q.ack)
         req_nxt = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_q.req <= RESET_VAL;
         hs_q.ack <= RESET_VAL;
      end else begin
         hs_q.req <= req_nxt;
         hs_q.ack <= hs_q.req & (hs_q.ack | enter_ok);
      end
   end

   assign hs = hs_q;

   p_clear_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_q.req && !hs_q.ack) |=> hs_q.req);
   p_ack_falls_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !hs_q.req |=> !hs_q.ack);
   p_entry_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!hs_q.ack && !enter_ok) |=> !hs_q.ack);
   p_set_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!hs_q.req && set_block) |=> !hs_q.req);
endmodule

// File: rtl/can_mode_integ.sv
module can_mode_integ #(
   parameter int unsigned RUN_LEN = can_mode_pkg::CMC_RUN_LEN,
   parameter int unsigned OCC_LEN = can_mode_pkg::CMC_OCC_LEN
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic bit_strobe,
   input  logic rx_line,
   input  logic bus_off,
   output logic synced
);
   localparam int unsigned RUN_W = $clog2(RUN_LEN + 1);

   if (RUN_LEN < 2) begin : g_bad_run
      $error("can_mode_integ: RUN_LEN must be at least 2");
   end
   if (OCC_LEN < 1) begin : g_bad_occ
      $error("can_mode_integ: OCC_LEN must be at least 1");
   end

   logic [RUN_W-1:0] run_q;
   logic synced_q;
   logic run_done;
   logic sync_hit;

   assign run_done = bit_strobe & rx_line & ~hold & ~synced_q &
                     (run_q == RUN_W'(RUN_LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= '0;
      else if (hold || synced_q)
         run_q <= '0;
      else if (bit_strobe) begin
         if (!rx_line || run_done)
            run_q <= '0;
         else
            run_q <= run_q + 1'b1;
      end
   end

   if (OCC_LEN > 1) begin : g_occ
      localparam int unsigned OCC_W = $clog2(OCC_LEN + 1);
      logic [OCC_W-1:0] occ_q;
      logic last_occ;
      assign last_occ = (occ_q == OCC_W'(OCC_LEN - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            occ_q <= '0;
         else if (hold)
            occ_q <= '0;
         else if (run_done && bus_off)
            occ_q <= last_occ ? '0 : occ_q + 1'b1;
      end
      assign sync_hit = run_done & (~bus_off | last_occ);

      p_occ_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
         occ_q < OCC_W'(OCC_LEN));
   end else begin : g_no_occ
      assign sync_hit = run_done;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         synced_q <= 1'b0;
      else if (hold)
         synced_q <= 1'b0;
      else if (sync_hit)
         synced_q <= 1'b1;
   end

   assign synced = synced_q;

   p_run_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      run_q < RUN_W'(RUN_LEN));
   p_dominant_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_strobe && !rx_line && !hold) |=> (run_q == '0));
   p_hold_unsync_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> !synced_q);
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl #(
   parameter int unsigned RUN_LEN = can_mode_pkg::CMC_RUN_LEN,
   parameter int unsigned OCC_LEN = can_mode_pkg::CMC_OCC_LEN
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_wr,
   input  logic cpu_sleep,
   input  logic cpu_init,
   input  logic wake_pend,
   input  logic wake_en,
   input  logic rx_busy,
   input  logic tx_pending,
   input  logic rx_line,
   input  logic bit_strobe,
   input  logic bus_off,
   output logic sleep_req,
   output logic sleep_ack,
   output logic init_req,
   output logic init_ack,
   output logic tx_force_rec,
   output logic eng_abort,
   output logic cfg_wr_en,
   output logic bus_synced
);
   can_mode_pkg::cmc_hs_t slp_hs;
   can_mode_pkg::cmc_hs_t cfg_hs;
   logic bus_idle;
   logic integ_hold;

   assign bus_idle = ~rx_busy & ~tx_pending;

   can_mode_hs #(.RESET_VAL(1'b0)) u_sleep (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cpu_wr),
      .wr_val    (cpu_sleep),
      .set_block (wake_pend),
      .enter_ok  (bus_idle),
      .auto_clr  (wake_en & ~rx_line),
      .hs        (slp_hs)
   );

   can_mode_hs #(.RESET_VAL(1'b1)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cpu_wr),
      .wr_val    (cpu_init),
      .set_block (1'b0),
      .enter_ok  (1'b1),
      .auto_clr  (1'b0),
      .hs        (cfg_hs)
   );

   assign integ_hold = cfg_hs.req | cfg_hs.ack;

   can_mode_integ #(.RUN_LEN(RUN_LEN), .OCC_LEN(OCC_LEN)) u_integ (
      .clk        (clk),
      .rst_n      (rst_n),
      .hold       (integ_hold),
      .bit_strobe (bit_strobe),
      .rx_line    (rx_line),
      .bus_off    (bus_off),
      .synced     (bus_synced)
   );

   assign sleep_req    = slp_hs.req;
   assign sleep_ack    = slp_hs.ack;
   assign init_req     = cfg_hs.req;
   assign init_ack     = cfg_hs.ack;
   assign eng_abort    = cfg_hs.req & ~cfg_hs.ack;
   assign cfg_wr_en    = cfg_hs.req & cfg_hs.ack;
   assign tx_force_rec = cfg_hs.req | ~bus_synced;

   p_abort_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      eng_abort |=> !eng_abort);
   p_cfg_unsynced_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_en |-> (tx_force_rec && !bus_synced));
   p_wake_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_ack && wake_en && !rx_line) |=> !sleep_req);
endmodule

// File: tb/can_mode_ctrl_test.sv
module can_mode_ctrl_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_wr = 0, cpu_sleep = 0, cpu_init = 0;
   logic wake_pend = 0, wake_en = 0, rx_busy = 0, tx_pending = 0;
   logic rx_line = 1, bit_strobe = 0, bus_off = 0;
   logic sleep_req, sleep_ack, init_req, init_ack;
   logic tx_force_rec, eng_abort, cfg_wr_en, bus_synced;

   int checks = 0;
   int fails = 0;
   int cycles = 0;
   bit running = 0;

   // reference model state
   bit m_sreq, m_sack, m_ireq, m_iack, m_sync;
   int m_run, m_occ;

   always #4 clk = ~clk;

   can_mode_ctrl uut (
      .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_sleep(cpu_sleep),
      .cpu_init(cpu_init), .wake_pend(wake_pend), .wake_en(wake_en),
      .rx_busy(rx_busy), .tx_pending(tx_pending), .rx_line(rx_line),
      .bit_strobe(bit_strobe), .bus_off(bus_off), .sleep_req(sleep_req),
      .sleep_ack(sleep_ack), .init_req(init_req), .init_ack(init_ack),
      .tx_force_rec(tx_force_rec), .eng_abort(eng_abort),
      .cfg_wr_en(cfg_wr_en), .bus_synced(bus_synced)
   );

   task automatic chk(string what, string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %b expected %b at cycle %0d",
                  req, what, act, exp, cycles);
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sreq <= 0; m_sack <= 0; m_ireq <= 1; m_iack <= 1;
         m_sync <= 0; m_run <= 0; m_occ <= 0;
      end else begin
         bit s, i, y;
         int r, o;
         s = m_sreq; i = m_ireq; y = m_sync; r = m_run; o = m_occ;
         if (cpu_wr) begin
            if (cpu_sleep && !wake_pend) s = 1;
            if (!cpu_sleep && m_sack) s = 0;
            if (cpu_init) i = 1;
            if (!cpu_init && m_iack) i = 0;
         end
         if (m_sack && wake_en && !rx_line) s = 0;
         if (m_ireq || m_iack) begin
            y = 0; r = 0; o = 0;
         end else if (!m_sync && bit_strobe) begin
            if (!rx_line) r = 0;
            else if (r == 10) begin
               r = 0;
               if (!bus_off) y = 1;
               else if (o == 127) begin y = 1; o = 0; end
               else o++;
            end else r++;
         end
         m_sack <= m_sreq && (m_sack || (!rx_busy && !tx_pending));
         m_iack <= m_ireq;
         m_sreq <= s; m_ireq <= i; m_sync <= y; m_run <= r; m_occ <= o;
      end
   end

   always @(negedge clk) begin
      cycles++;
      if (running) begin
         chk("sleep_req", "R3/R4/R6", sleep_req, m_sreq);
         chk("sleep_ack", "R2/R7", sleep_ack, m_sack);
         chk("init_req", "R5/R6", init_req, m_ireq);
         chk("init_ack", "R5/R7", init_ack, m_iack);
         chk("eng_abort", "R5", eng_abort, m_ireq && !m_iack);
         chk("cfg_wr_en", "R8", cfg_wr_en, m_ireq && m_iack);
         chk("bus_synced", "R9/R10", bus_synced, m_sync);
         chk("tx_force_rec", "R11", tx_force_rec, m_ireq || !m_sync);
      end
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic tick(int n = 1);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic wr(bit s, bit i);
      cpu_sleep = s; cpu_init = i; cpu_wr = 1;
      tick();
      cpu_wr = 0;
   endtask

   task automatic strobe(bit rx);
      bit_strobe = 1; rx_line = rx;
      tick();
      bit_strobe = 0; rx_line = 1;
      tick();
   endtask

   initial begin
      tick(3);
      rst_n = 1;
      tick();
      // R1: reset state
      chk("init_req", "R1", init_req, 1);
      chk("init_ack", "R1", init_ack, 1);
      chk("sleep_req", "R1", sleep_req, 0);
      chk("sleep_ack", "R1", sleep_ack, 0);
      chk("tx_force_rec", "R1", tx_force_rec, 1);
      chk("bus_synced", "R1", bus_synced, 0);
      running = 1;

      // leave configuration, integrate with a dominant break (R9)
      wr(0, 0);
      tick();
      for (int k = 0; k < 5; k++) strobe(1);
      strobe(0);
      for (int k = 0; k < 10; k++) strobe(1);
      chk("bus_synced early", "R9", bus_synced, 0);
      strobe(1);
      chk("bus_synced", "R9", bus_synced, 1);
      chk("tx_force_rec", "R11", tx_force_rec, 0);

      // sleep while busy, early clear attempt (R2, R6)
      rx_busy = 1;
      wr(1, 0);
      tick(3);
      wr(0, 0);
      chk("sleep_req held", "R6", sleep_req, 1);
      chk("sleep_ack while busy", "R2", sleep_ack, 0);
      rx_busy = 0; tx_pending = 1;
      tick(2);
      tx_pending = 0;
      tick(2);
      chk("sleep_ack idle", "R2", sleep_ack, 1);
      wr(0, 0);
      tick();
      chk("sleep_ack fall", "R7", sleep_ack, 0);

      // wake flag blocks set (R3)
      wake_pend = 1;
      wr(1, 0);
      chk("sleep_req blocked", "R3", sleep_req, 0);
      wake_pend = 0;

      // bus activity without and with wake-up (R4)
      wr(1, 0);
      tick(2);
      rx_line = 0;
      tick(2);
      chk("sleep_req no wake", "R4", sleep_req, 1);
      wake_en = 1;
      tick();
      chk("sleep_req woken", "R4", sleep_req, 0);
      rx_line = 1; wake_en = 0;
      tick(2);

      // configuration entry, early clear, bus-off integration (R5, R10)
      wr(0, 1);
      chk("eng_abort", "R5", eng_abort, 1);
      chk("tx_force_rec", "R11", tx_force_rec, 1);
      wr(0, 0);
      chk("init_req locked", "R6", init_req, 1);
      chk("cfg_wr_en", "R8", cfg_wr_en, 1);
      tick(2);
      bus_off = 1;
      wr(0, 0);
      tick();
      for (int k = 0; k < 127 * 11 + 10; k++) strobe(1);
      chk("bus_synced early", "R10", bus_synced, 0);
      strobe(1);
      chk("bus_synced", "R10", bus_synced, 1);
      tick(3);

      running = 0;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule